// File: doc/BRIEF.md
# Mailbox Responder Register File

This block is the device side of a host-to-device request/response mailbox. It is reached through a small register port with four dword registers. The host streams a request object, one dword at a time, into the write mailbox. It then starts processing with a control write, polls a status word, and collects the response from the read mailbox. The host advances through the response by writing any value to the read mailbox. An object always begins with two header dwords. The first carries a 16-bit vendor code and an 8-bit object type. The second carries the total object length in dwords, header included.

A built-in handler answers every accepted request after a fixed number of cycles. A request whose header names the discovery protocol receives a three-dword answer that describes one supported protocol and gives the index of the next one. Any other request is returned unchanged (echo). The request and the response share one buffer. An abort write returns the mailbox to a clean idle state from any condition.

Top module: `mbx_responder`

## Requirements
- R1: After reset every register reads zero. The address map is: 0 control, 1 status, 2 write mailbox, 3 read mailbox. The control and write-mailbox addresses always read zero. In the status word, bit 0 is busy, bit 1 is error and bit 2 is response-ready.
- R2: Writes to the write mailbox are stored in arrival order, up to DEPTH dwords. A write that arrives while DEPTH dwords are already held sets error.
- R3: A control write with bit 0 (start) set, made while idle with no error, is accepted when at least two dwords are held and bits [17:0] of the second dword equal the number held. Busy is then set for exactly LATENCY cycles, beginning the cycle after the write, and response-ready follows in the next cycle.
- R4: A start whose stored length disagrees with the held count, or that has fewer than two dwords held, sets error. It raises neither busy nor response-ready, and it discards the request.
- R5: A request that is not discovery is answered with the identical dword sequence.
- R6: A request whose first dword has vendor 0x0001 in bits [15:0] and type 0 in bits [23:16] is discovery. The answer is: the same first dword, then length 3, then an entry word. The entry word holds vendor in [15:0], type in [23:16] and the next index in [31:24]. The index is taken from bits [7:0] of the third request dword, or is 0 when that dword is absent. Index 0 gives 0x01000001, index 1 gives ECHO_TYPE/ECHO_VID with next index 0, and any other index gives zero.
- R7: While response-ready is set, the read mailbox shows the current response dword. A write of any value to it advances to the next dword. Response-ready stays set until the last dword is acknowledged, and then the mailbox returns to idle.
- R8: While response-ready is clear, the read mailbox reads zero and writes to it have no effect.
- R9: Write-mailbox writes are ignored while busy, ready or in error. A start is ignored in those states. Error stays set until an abort.
- R10: A control write with bit 1 (abort) set clears busy, error and response-ready in the next cycle and discards any partial request or response. Abort takes precedence over start in the same write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register dword address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |

## Verification
A register write is taken on a rising edge. Its effect on status and on the read mailbox is visible combinationally in that same cycle after the edge, so error, abort and acknowledge results are due one edge after the write. Busy appears one edge after an accepted start and lasts LATENCY cycles, and response-ready rises on the following edge. The bench drives on falling edges and updates a behavioural queue model on each rising edge. One nanosecond after every rising edge it compares read data for the address being driven against that model. Explicit checks sample on falling edges, directly after the edge that consumed the stimulus.

// File: rtl/mbx_pkg.sv
`timescale 1ns / 1ps
// Shared constants, types and the discovery table for the mailbox responder.
package mbx_pkg;

    // Register dword addresses seen by the host.
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_WMB  = 2'd2,
        REG_RMB  = 2'd3
    } reg_addr_e;

    // Control and status bit positions.
    localparam int CTRL_GO    = 0;
    localparam int CTRL_ABORT = 1;
    localparam int STAT_BUSY  = 0;
    localparam int STAT_ERR   = 1;
    localparam int STAT_READY = 2;

    // Width of the length field in the second header dword.
    localparam int LEN_W = 18;

    // Identity of the discovery protocol.
    localparam logic [15:0] DISC_VID  = 16'h0001;
    localparam logic [7:0]  DISC_TYPE = 8'h00;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_READY = 2'd2
    } mbx_state_e;

    // Discovery entry for a given index: {next, type, vendor}.
    function automatic logic [31:0] disc_entry(input logic [7:0]  idx,
                                               input logic [15:0] evid,
                                               input logic [7:0]  etype);
        case (idx)
            8'd0:    return {8'd1, DISC_TYPE, DISC_VID};
            8'd1:    return {8'd0, etype, evid};
            default: return 32'd0;
        endcase
    endfunction

endpackage

// File: rtl/mbx_seq.sv
`timescale 1ns / 1ps
// Mailbox sequencer: holds idle/busy/ready state, the sticky error flag and
// the handler latency counter, and turns decoded host strobes into buffer
// actions. Assumes at most one register write per cycle and LATENCY >= 1.
module mbx_seq
    import mbx_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic abort_req,
    input  logic go_req,
    input  logic wmb_req,
    input  logic ack_req,
    input  logic buf_full,
    input  logic len_ok,
    input  logic last_word,
    output logic busy,
    output logic ready,
    output logic err,
    output logic push_en,
    output logic commit,
    output logic ack_en,
    output logic clear
);
    localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
    localparam logic [CNT_W-1:0] LAT_LOAD = CNT_W'(LATENCY - 1);

    mbx_state_e       state;
    logic [CNT_W-1:0] lat_cnt;
    logic             idle_ok;
    logic             go_acc;
    logic             ovf;

    // Decode which host strobes are honoured in the present state.
    assign idle_ok = (state == ST_IDLE) && !err;
    assign go_acc  = !abort_req && go_req && idle_ok;
    assign push_en = !abort_req && wmb_req && idle_ok && !buf_full;
    assign ovf     = !abort_req && wmb_req && idle_ok && buf_full;
    assign commit  = !abort_req && (state == ST_BUSY) && (lat_cnt == '0);
    assign ack_en  = !abort_req && ack_req && (state == ST_READY);
    assign clear   = abort_req || (go_acc && !len_ok) || (ack_en && last_word);
    assign busy    = (state == ST_BUSY);
    assign ready   = (state == ST_READY);

    // State, error and latency counter update; abort overrides all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            err     <= 1'b0;
            lat_cnt <= '0;
        end else if (abort_req) begin
            state   <= ST_IDLE;
            err     <= 1'b0;
            lat_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (go_acc && len_ok) begin
                        state   <= ST_BUSY;
                        lat_cnt <= LAT_LOAD;
                    end else if (go_acc || ovf) begin
                        err <= 1'b1;
                    end
                end
                ST_BUSY: begin
                    if (lat_cnt == '0) state <= ST_READY;
                    else               lat_cnt <= lat_cnt - CNT_W'(1);
                end
                ST_READY: begin
                    if (ack_en && last_word) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // An accepted start with a consistent length enters busy.
    p_go_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (go_req && !abort_req && !busy && !ready && !err && len_ok) |=> busy);

    // Ready holds until the final dword is acknowledged or an abort.
    p_ready_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !(ack_req && last_word) && !abort_req) |=> ready);

    // Abort leaves the mailbox clean in the next cycle.
    p_abort_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> (!busy && !err && !ready));

    // Error is sticky until abort.
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !abort_req) |=> err);

endmodule

// File: rtl/mbx_buffer.sv
`timescale 1ns / 1ps
// Shared request/response store. Collects request dwords in order, rewrites
// the discovery answer in place on commit, and walks a read pointer over the
// response. Assumes DEPTH >= 3 so a discovery answer fits.
module mbx_buffer
    import mbx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push_en,
    input  logic [31:0]      push_data,
    input  logic             commit,
    input  logic             disc_mode,
    input  logic [31:0]      disc_word,
    input  logic             ack_en,
    output logic [CW-1:0]    wcnt,
    output logic             full,
    output logic [23:0]      hdr_id,
    output logic [LEN_W-1:0] hdr_len,
    output logic [7:0]       pay_idx,
    output logic [31:0]      rd_word,
    output logic             last_word
);
    localparam int IW = $clog2(DEPTH);

    logic [31:0]   mem [DEPTH];
    logic [CW-1:0] rptr;
    logic [CW-1:0] rlen;

    // Storage, fill count, response length and read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            wcnt <= '0;
            rptr <= '0;
            rlen <= '0;
        end else if (clear) begin
            wcnt <= '0;
            rptr <= '0;
            rlen <= '0;
        end else begin
            if (push_en) begin
                mem[wcnt[IW-1:0]] <= push_data;
                wcnt              <= wcnt + CW'(1);
            end
            if (commit) begin
                rptr <= '0;
                if (disc_mode) begin
                    mem[IW'(1)] <= 32'd3;
                    mem[IW'(2)] <= disc_word;
                    rlen        <= CW'(3);
                end else begin
                    rlen <= wcnt;
                end
            end
            if (ack_en) rptr <= rptr + CW'(1);
        end
    end

    // Views of the header fields and the current response dword.
    assign full      = (wcnt == CW'(DEPTH));
    assign hdr_id    = mem[0][23:0];
    assign hdr_len   = mem[1][LEN_W-1:0];
    assign pay_idx   = mem[2][7:0];
    assign rd_word   = mem[rptr[IW-1:0]];
    assign last_word = ((rptr + CW'(1)) == rlen);

    // The fill count never passes the buffer depth.
    p_wcnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt <= CW'(DEPTH));

endmodule

// File: rtl/mbx_handler.sv
`timescale 1ns / 1ps
// Built-in protocol handler: checks the request length against the header,
// recognises discovery and builds the discovery entry. Purely combinational;
// assumes its inputs are stable while the sequencer is busy.
module mbx_handler
    import mbx_pkg::*;
#(
    parameter int          DEPTH     = 8,
    parameter int          CW        = $clog2(DEPTH + 1),
    parameter logic [15:0] ECHO_VID  = 16'h1E5A,
    parameter logic [7:0]  ECHO_TYPE = 8'h07
) (
    input  logic [CW-1:0]    wcnt,
    input  logic [23:0]      hdr_id,
    input  logic [LEN_W-1:0] hdr_len,
    input  logic [7:0]       pay_idx,
    output logic             len_ok,
    output logic             disc_mode,
    output logic [31:0]      disc_word
);
    logic [7:0] idx;

    // Length agrees with the held dword count and covers the header.
    assign len_ok = (wcnt >= CW'(2)) && (hdr_len == LEN_W'(wcnt));

    // Discovery identity and index selection.
    assign disc_mode = (hdr_id[15:0] == DISC_VID) && (hdr_id[23:16] == DISC_TYPE);
    assign idx       = (wcnt > CW'(2)) ? pay_idx : 8'd0;

    // Entry word from the computed table.
    assign disc_word = disc_entry(idx, ECHO_VID, ECHO_TYPE);

endmodule

// File: rtl/mbx_responder.sv
`timescale 1ns / 1ps
// Mailbox responder top: decodes the four-register host port, wires the
// sequencer, buffer and handler, and muxes read data. Assumes one register
// access per cycle; reads have no side effects.
module mbx_responder
    import mbx_pkg::*;
#(
    parameter int          DEPTH     = 8,
    parameter int          LATENCY   = 4,
    parameter logic [15:0] ECHO_VID  = 16'h1E5A,
    parameter logic [7:0]  ECHO_TYPE = 8'h07
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    localparam int CW = $clog2(DEPTH + 1);

    reg_addr_e        addr;
    logic             abort_req, go_req, wmb_req, ack_req;
    logic             busy, ready, err;
    logic             push_en, commit, ack_en, clear;
    logic             buf_full, len_ok, last_word, disc_mode;
    logic [CW-1:0]    wcnt;
    logic [23:0]      hdr_id;
    logic [LEN_W-1:0] hdr_len;
    logic [7:0]       pay_idx;
    logic [31:0]      disc_word, rd_word;

    // Host write decode.
    assign addr      = reg_addr_e'(reg_addr);
    assign abort_req = reg_wr && (addr == REG_CTRL) && reg_wdata[CTRL_ABORT];
    assign go_req    = reg_wr && (addr == REG_CTRL) && reg_wdata[CTRL_GO];
    assign wmb_req   = reg_wr && (addr == REG_WMB);
    assign ack_req   = reg_wr && (addr == REG_RMB);

    mbx_seq #(.LATENCY(LATENCY)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .abort_req(abort_req), .go_req(go_req), .wmb_req(wmb_req), .ack_req(ack_req),
        .buf_full(buf_full), .len_ok(len_ok), .last_word(last_word),
        .busy(busy), .ready(ready), .err(err),
        .push_en(push_en), .commit(commit), .ack_en(ack_en), .clear(clear)
    );

    mbx_buffer #(.DEPTH(DEPTH), .CW(CW)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .clear(clear), .push_en(push_en), .push_data(reg_wdata),
        .commit(commit), .disc_mode(disc_mode), .disc_word(disc_word), .ack_en(ack_en),
        .wcnt(wcnt), .full(buf_full), .hdr_id(hdr_id), .hdr_len(hdr_len),
        .pay_idx(pay_idx), .rd_word(rd_word), .last_word(last_word)
    );

    mbx_handler #(.DEPTH(DEPTH), .CW(CW), .ECHO_VID(ECHO_VID), .ECHO_TYPE(ECHO_TYPE)) u_hdl (
        .wcnt(wcnt), .hdr_id(hdr_id), .hdr_len(hdr_len), .pay_idx(pay_idx),
        .len_ok(len_ok), .disc_mode(disc_mode), .disc_word(disc_word)
    );

    // Read data mux; the read mailbox shows zero unless a response is ready.
    always_comb begin
        reg_rdata = '0;
        case (addr)
            REG_STAT: begin
                reg_rdata[STAT_BUSY]  = busy;
                reg_rdata[STAT_ERR]   = err;
                reg_rdata[STAT_READY] = ready;
            end
            REG_RMB:  if (ready) reg_rdata = rd_word;
            default:  reg_rdata = '0;
        endcase
    end

    // Request dwords offered while busy do not enter the buffer.
    p_busy_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wmb_req) |=> $stable(wcnt));

endmodule

// File: tb/mbx_responder_test.sv
`timescale 1ns / 1ps
module mbx_responder_test;
    localparam int          DEPTH = 8;
    localparam int          LAT   = 4;
    localparam logic [15:0] EV    = 16'h1E5A;
    localparam logic [7:0]  ET    = 8'h07;
    localparam logic [1:0]  A_CTRL = 2'd0, A_STAT = 2'd1, A_WMB = 2'd2, A_RMB = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = A_STAT;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int    nchk = 0, nfail = 0, cyc = 0;
    string cur_req = "R1";
    bit    cmp_en = 1'b0;

    always #2.5 clk = ~clk;

    mbx_responder #(.DEPTH(DEPTH), .LATENCY(LAT), .ECHO_VID(EV), .ECHO_TYPE(ET)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference model.
    int          m_busy = 0, m_err = 0, m_ready = 0, m_lat = 0;
    logic [31:0] req_q[$];
    logic [31:0] resp_q[$];

    task automatic build_resp();
        logic [31:0] h1;
        logic [7:0]  ix;
        h1 = req_q[0];
        resp_q.delete();
        if (h1[15:0] == 16'h0001 && h1[23:16] == 8'h00) begin
            ix = (req_q.size() > 2) ? req_q[2][7:0] : 8'd0;
            resp_q.push_back(h1);
            resp_q.push_back(32'd3);
            if (ix == 0)      resp_q.push_back(32'h0100_0001);
            else if (ix == 1) resp_q.push_back({8'd0, ET, EV});
            else              resp_q.push_back(32'd0);
        end else begin
            foreach (req_q[i]) resp_q.push_back(req_q[i]);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_err = 0; m_ready = 0; m_lat = 0;
            req_q.delete(); resp_q.delete();
        end else if (reg_wr && reg_addr == A_CTRL && reg_wdata[1]) begin
            m_busy = 0; m_err = 0; m_ready = 0; m_lat = 0;
            req_q.delete(); resp_q.delete();
        end else if (m_busy != 0) begin
            if (m_lat == 0) begin
                build_resp();
                m_busy = 0;
                m_ready = 1;
            end else m_lat--;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL: if (reg_wdata[0] && m_ready == 0 && m_err == 0) begin
                    if (req_q.size() >= 2 && req_q[1][17:0] == 18'(req_q.size())) begin
                        m_busy = 1; m_lat = LAT - 1;
                    end else begin
                        m_err = 1; req_q.delete();
                    end
                end
                A_WMB: if (m_ready == 0 && m_err == 0) begin
                    if (req_q.size() == DEPTH) m_err = 1;
                    else req_q.push_back(reg_wdata);
                end
                A_RMB: if (m_ready != 0) begin
                    void'(resp_q.pop_front());
                    if (resp_q.size() == 0) begin
                        m_ready = 0; req_q.delete();
                    end
                end
                default: ;
            endcase
        end
    end

    function automatic logic [31:0] model_view();
        case (reg_addr)
            A_STAT:  return {29'd0, m_ready[0], m_err[0], m_busy[0]};
            A_RMB:   return (m_ready != 0) ? resp_q[0] : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    // Compare the design with the model after every rising edge.
    always @(posedge clk) begin
        #1;
        if (cmp_en) chk(reg_rdata === model_view(), cur_req, reg_rdata, model_view());
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            nfail++;
            $display("FAIL watchdog (all requirements) actual=%0d expected=<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = A_STAT; reg_wdata = '0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.2;
        d = reg_rdata;
        reg_addr = A_STAT;
    endtask

    task automatic expect_reg(input logic [1:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        peek(a, v);
        chk(v === exp, req, v, exp);
    endtask

    task automatic send(input logic [31:0] q[$]);
        foreach (q[i]) wr(A_WMB, q[i]);
    endtask

    task automatic wait_ready();
        logic [31:0] s;
        int n = 0;
        peek(A_STAT, s);
        while (!s[2] && n < 100) begin
            @(negedge clk);
            peek(A_STAT, s);
            n++;
        end
    endtask

    task automatic drain(input logic [31:0] q[$], input string req);
        foreach (q[i]) begin
            expect_reg(A_RMB, q[i], req);
            wr(A_RMB, 32'hFFFF_0000 + i);
            if (i < q.size() - 1) expect_reg(A_STAT, 32'd4, "R7 ready held");
            else                  expect_reg(A_STAT, 32'd0, "R7 idle after last ack");
        end
    endtask

    initial begin
        logic [31:0] q[$];
        logic [31:0] e[$];
        logic [31:0] s;
        int n;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1'b1;
        expect_reg(A_CTRL, 32'd0, "R1 ctrl");
        expect_reg(A_STAT, 32'd0, "R1 status");
        expect_reg(A_WMB,  32'd0, "R1 wmb");
        expect_reg(A_RMB,  32'd0, "R1 rmb");

        // R3 and R5: echo round trip with busy timing
        cur_req = "R5";
        q.delete();
        q.push_back({8'd0, ET, EV}); q.push_back(32'd4);
        q.push_back(32'hA5A5_0001); q.push_back(32'h5A5A_0002);
        send(q);
        wr(A_CTRL, 32'd1);
        n = 0;
        peek(A_STAT, s);
        while (s[0] && n < 50) begin
            n++;
            @(negedge clk);
            peek(A_STAT, s);
        end
        chk(n == LAT, "R3 busy cycles", n, LAT);
        chk(s == 32'd4, "R3 ready after busy", s, 32'd4);
        drain(q, "R5 echo");

        // R6: discovery index 0, 1, out of range, and no payload
        cur_req = "R6";
        q.delete(); q.push_back(32'h0000_0001); q.push_back(32'd3); q.push_back(32'd0);
        send(q); wr(A_CTRL, 32'd1); wait_ready();
        e.delete(); e.push_back(32'h0000_0001); e.push_back(32'd3); e.push_back(32'h0100_0001);
        drain(e, "R6 index0");
        q[2] = 32'h0000_0001;
        send(q); wr(A_CTRL, 32'd1); wait_ready();
        e[2] = {8'd0, ET, EV};
        drain(e, "R6 index1");
        q[2] = 32'h0000_0005;
        send(q); wr(A_CTRL, 32'd1); wait_ready();
        e[2] = 32'd0;
        drain(e, "R6 index out of range");
        q.delete(); q.push_back(32'h0000_0001); q.push_back(32'd2);
        send(q); wr(A_CTRL, 32'd1); wait_ready();
        e[2] = 32'h0100_0001;
        drain(e, "R6 no payload");

        // R8: acknowledge while not ready has no effect
        cur_req = "R8";
        wr(A_RMB, 32'd123);
        expect_reg(A_STAT, 32'd0, "R8 status");
        expect_reg(A_RMB, 32'd0, "R8 rmb zero");
        q.delete(); q.push_back(32'h0003_BEEF); q.push_back(32'd3); q.push_back(32'hCAFE_0000);
        send(q); wr(A_CTRL, 32'd1); wait_ready();
        drain(q, "R8 response starts at first dword");

        // R9: writes while busy or ready are ignored
        cur_req = "R9";
        q.delete(); q.push_back(32'h0011_2233); q.push_back(32'd3); q.push_back(32'h0000_0077);
        send(q); wr(A_CTRL, 32'd1);
        wr(A_WMB, 32'hDEAD_0001);
        wr(A_WMB, 32'hDEAD_0002);
        wait_ready();
        wr(A_WMB, 32'hDEAD_0003);
        wr(A_CTRL, 32'd1);
        expect_reg(A_STAT, 32'd4, "R9 start ignored while ready");
        drain(q, "R9 response unchanged");

        // R4: length mismatch, then R9 error stickiness, R10 abort
        cur_req = "R4";
        q.delete(); q.push_back(32'h0011_2233); q.push_back(32'd5); q.push_back(32'd9);
        send(q); wr(A_CTRL, 32'd1);
        expect_reg(A_STAT, 32'd2, "R4 mismatch error");
        cur_req = "R9";
        wr(A_CTRL, 32'd1);
        expect_reg(A_STAT, 32'd2, "R9 start ignored in error");
        wr(A_WMB, 32'h1234_5678);
        expect_reg(A_STAT, 32'd2, "R9 error sticky");
        cur_req = "R10";
        wr(A_CTRL, 32'd2);
        expect_reg(A_STAT, 32'd0, "R10 abort clears error");
        cur_req = "R4";
        wr(A_WMB, 32'h0011_2233);
        wr(A_CTRL, 32'd1);
        expect_reg(A_STAT, 32'd2, "R4 single dword");
        wr(A_CTRL, 32'd2);

        // R2: full-depth round trip, then overflow
        cur_req = "R2";
        q.delete(); q.push_back(32'h0044_0001); q.push_back(32'd8);
        for (int i = 2; i < DEPTH; i++) q.push_back(32'h1000_0000 + i);
        send(q);
        expect_reg(A_STAT, 32'd0, "R2 full without error");
        wr(A_CTRL, 32'd1); wait_ready();
        drain(q, "R2 order at full depth");
        send(q);
        wr(A_WMB, 32'h9999_9999);
        expect_reg(A_STAT, 32'd2, "R2 overflow error");
        wr(A_CTRL, 32'd2);

        // R10: partial request discarded
        cur_req = "R10";
        wr(A_WMB, 32'h0055_0000);
        wr(A_CTRL, 32'd2);
        q.delete(); q.push_back(32'h0066_0000); q.push_back(32'd3); q.push_back(32'h0000_0042);
        send(q); wr(A_CTRL, 32'd1); wait_ready();
        drain(q, "R10 partial request discarded");
        // R10: abort while busy
        send(q); wr(A_CTRL, 32'd1);
        wr(A_CTRL, 32'd2);
        expect_reg(A_STAT, 32'd0, "R10 abort while busy");
        wr(A_CTRL, 32'd1);
        expect_reg(A_STAT, 32'd2, "R10 request gone after abort");
        wr(A_CTRL, 32'd2);
        // R10: abort mid-response
        send(q); wr(A_CTRL, 32'd1); wait_ready();
        wr(A_RMB, 32'd0);
        wr(A_CTRL, 32'd2);
        expect_reg(A_STAT, 32'd0, "R10 abort mid-response");
        expect_reg(A_RMB, 32'd0, "R10 response discarded");
        // R10: abort wins over start in one write
        send(q);
        wr(A_CTRL, 32'd3);
        expect_reg(A_STAT, 32'd0, "R10 abort beats start");
        wr(A_CTRL, 32'd1);
        expect_reg(A_STAT, 32'd2, "R10 request discarded by combined write");
        wr(A_CTRL, 32'd2);
        expect_reg(A_STAT, 32'd0, "R10 final clean");

        @(negedge clk);
        cmp_en = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule